// File: doc/BRIEF.md
# MSI Coherent L1 Cache Controller

This block is the child-side coherence engine of a small blocking first-level cache. Every address owns one line, and each line holds a data word, a coherence state (invalid, shared or modified) and a record of any upgrade still awaiting the parent. The processor feeds loads and stores through a request queue and collects load data and store acknowledgements from a response queue. The parent level talks to the controller through one outgoing and one incoming message queue. Each message carries a kind bit (0 = request, 1 = response), an address, a target state and a data word with a flag that says whether the data is meaningful.

The controller takes one action per cycle. An incoming parent message wins over everything else. A voluntary downgrade command, which the surrounding cache uses to evict lines, comes next. The processor request at the head of its queue comes last. On a miss the processor request stays at the head of its queue. The controller asks the parent for an upgrade, and once the upgrade response is installed the same request completes as a hit on the next cycle.

States are encoded as I=0, S=1, M=2, so the order M > S > I is a plain unsigned compare. All queue edges use valid/ready handshakes. A transfer happens in a cycle where both valid and ready are high at the rising clock edge.

Top module: `msi_l1_ctrl`

## Requirements
- R1: After reset every line is in I with no pending upgrade, and no output valid is asserted while no input valid is asserted.
- R2: A load whose line state is S or M returns the line data on the processor response queue (store flag 0) and is dequeued in the same cycle.
- R3: A store whose line is in M writes its data into the line, returns an acknowledgement with store flag 1 and is dequeued. A store to a line in S or I is not a hit.
- R4: On a miss whose line has no pending upgrade, the controller sends a request message (kind 0) for that address with target S for a load or M for a store. It records that target as pending and leaves the processor request undequeued.
- R5: While a line has a pending upgrade, no further request message is sent for that address.
- R6: An upgrade response (kind 1) is always accepted. It installs the data only if the line was in I, sets the state to the response target and clears the pending record. The stalled processor request then completes as a hit on the following cycle.
- R7: A downgrade request (kind 0) whose target is below the line state is answered with a response message carrying that target. Its data flag is 1 with the line data only when the line was in M. The line then takes the target state.
- R8: A downgrade request whose target is at or above the line state is dequeued with no outgoing message and no change to the line.
- R9: A voluntary downgrade is held off (not dequeued, nothing sent) while its line has a pending upgrade. Otherwise it sends the same response message as R7 and lowers the state. If the target is not below the state, it is consumed with no effect.
- R10: When several sources are valid in one cycle, only the incoming parent message is serviced. With no parent message, only the voluntary downgrade is serviced.
- R11: While the processor response queue is not ready, a hit is not dequeued and the line is not changed.
- R12: While the outgoing parent queue is not ready, a downgrade or miss that needs to send a message is not dequeued and leaves the line and its pending record unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preq_valid | input | 1 | Processor request at queue head |
| preq_ready | output | 1 | Dequeue processor request |
| preq_store | input | 1 | 1 = store, 0 = load |
| preq_addr | input | ADDR_W | Request address |
| preq_data | input | DATA_W | Store data |
| presp_valid | output | 1 | Processor response available |
| presp_ready | input | 1 | Processor response queue has room |
| presp_store | output | 1 | 1 = store acknowledgement, 0 = load data |
| presp_data | output | DATA_W | Load data (0 for acknowledgements) |
| pout_valid | output | 1 | Outgoing parent message available |
| pout_ready | input | 1 | Outgoing parent queue has room |
| pout_resp | output | 1 | Message kind: 0 request, 1 response |
| pout_addr | output | ADDR_W | Message address |
| pout_state | output | 2 | Target state |
| pout_has_data | output | 1 | Data word is meaningful |
| pout_data | output | DATA_W | Data word |
| pin_valid | input | 1 | Incoming parent message at queue head |
| pin_ready | output | 1 | Dequeue incoming parent message |
| pin_resp | input | 1 | Message kind: 0 request, 1 response |
| pin_addr | input | ADDR_W | Message address |
| pin_state | input | 2 | Target state |
| pin_data | input | DATA_W | Data word |
| vd_valid | input | 1 | Voluntary downgrade command |
| vd_ready | output | 1 | Dequeue voluntary downgrade command |
| vd_addr | input | ADDR_W | Line to downgrade |
| vd_state | input | 2 | Target state |

## Verification
The bench follows the line through every upgrade and downgrade step and checks the result at the ports. An upgrade from S to M arrives carrying stale data, and a design that installed it anyway would return that stale word on the next load. A downgrade that finds the line already low must vanish silently; a design that answered it would emit a spurious response the parent never expects. Voluntary downgrades are issued against lines with a pending upgrade, where a design that let them through would break the single-owner invariant. Both back-pressure cases are exercised, and a design that moved state while a queue was full would lose a message or double-apply a store.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_M = 2'd2
  } msi_t;

  typedef struct packed {
    logic v;
    msi_t st;
  } pend_t;

  localparam int NUM_RD = 3;
  localparam int RD_PIN = 0;
  localparam int RD_VD  = 1;
  localparam int RD_PRQ = 2;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int AW     = 3,
  parameter int DATA_W = 16,
  parameter int NRD    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_idx,
  input  logic                      wr_st_en,
  input  msi_t                      wr_st,
  input  logic                      wr_pend_en,
  input  pend_t                     wr_pend,
  input  logic                      wr_dat_en,
  input  logic [DATA_W-1:0]         wr_dat,
  input  logic [NRD-1:0][AW-1:0]    rd_idx,
  output msi_t [NRD-1:0]            rd_st,
  output pend_t [NRD-1:0]           rd_pend,
  output logic [NRD-1:0][DATA_W-1:0] rd_dat,
  output msi_t [LINES-1:0]          all_st,
  output logic [LINES-1:0]          all_pv
);
  msi_t  [LINES-1:0]             st_q, st_d;
  pend_t [LINES-1:0]             pd_q, pd_d;
  logic  [LINES-1:0][DATA_W-1:0] dt_q, dt_d;

  always_comb begin
    st_d = st_q;
    pd_d = pd_q;
    dt_d = dt_q;
    if (wr_en) begin
      if (wr_st_en)   st_d[wr_idx] = wr_st;
      if (wr_pend_en) pd_d[wr_idx] = wr_pend;
      if (wr_dat_en)  dt_d[wr_idx] = wr_dat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= {LINES{ST_I}};
      pd_q <= '0;
      dt_q <= '0;
    end else if (wr_en) begin
      st_q <= st_d;
      pd_q <= pd_d;
      dt_q <= dt_d;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_st[g]   = st_q[rd_idx[g]];
    assign rd_pend[g] = pd_q[rd_idx[g]];
    assign rd_dat[g]  = dt_q[rd_idx[g]];
  end

  for (genvar l = 0; l < LINES; l++) begin : g_vis
    assign all_st[l] = st_q[l];
    assign all_pv[l] = pd_q[l].v;
  end
endmodule

// File: rtl/msi_rule_engine.sv
module msi_rule_engine
  import msi_pkg::*;
#(
  parameter int AW     = 3,
  parameter int DATA_W = 16
) (
  input  logic              preq_valid,
  output logic              preq_ready,
  input  logic              preq_store,
  input  logic [AW-1:0]     preq_addr,
  input  logic [DATA_W-1:0] preq_data,
  output logic              presp_valid,
  input  logic              presp_ready,
  output logic              presp_store,
  output logic [DATA_W-1:0] presp_data,
  output logic              pout_valid,
  input  logic              pout_ready,
  output logic              pout_resp,
  output logic [AW-1:0]     pout_addr,
  output logic [1:0]        pout_state,
  output logic              pout_has_data,
  output logic [DATA_W-1:0] pout_data,
  input  logic              pin_valid,
  output logic              pin_ready,
  input  logic              pin_resp,
  input  logic [AW-1:0]     pin_addr,
  input  logic [1:0]        pin_state,
  input  logic [DATA_W-1:0] pin_data,
  input  logic              vd_valid,
  output logic              vd_ready,
  input  logic [AW-1:0]     vd_addr,
  input  logic [1:0]        vd_state,
  input  msi_t [NUM_RD-1:0]            cur_st,
  input  pend_t [NUM_RD-1:0]           cur_pend,
  input  logic [NUM_RD-1:0][DATA_W-1:0] cur_dat,
  output logic              wr_en,
  output logic [AW-1:0]     wr_idx,
  output logic              wr_st_en,
  output msi_t              wr_st,
  output logic              wr_pend_en,
  output pend_t             wr_pend,
  output logic              wr_dat_en,
  output logic [DATA_W-1:0] wr_dat
);
  logic prq_hit;
  msi_t prq_want;

  assign prq_want = preq_store ? ST_M : ST_S;
  assign prq_hit  = preq_store ? (cur_st[RD_PRQ] == ST_M) : (cur_st[RD_PRQ] != ST_I);

  always_comb begin
    preq_ready    = 1'b0;
    presp_valid   = 1'b0;
    presp_store   = 1'b0;
    presp_data    = '0;
    pout_valid    = 1'b0;
    pout_resp     = 1'b0;
    pout_addr     = '0;
    pout_state    = 2'd0;
    pout_has_data = 1'b0;
    pout_data     = '0;
    pin_ready     = 1'b0;
    vd_ready      = 1'b0;
    wr_en         = 1'b0;
    wr_idx        = '0;
    wr_st_en      = 1'b0;
    wr_st         = ST_I;
    wr_pend_en    = 1'b0;
    wr_pend       = '0;
    wr_dat_en     = 1'b0;
    wr_dat        = '0;

    if (pin_valid) begin
      wr_idx = pin_addr;
      if (pin_resp) begin
        // upgrade response always drains
        pin_ready  = 1'b1;
        wr_en      = 1'b1;
        wr_st_en   = 1'b1;
        wr_st      = msi_t'(pin_state);
        wr_pend_en = 1'b1;
        wr_pend    = '0;
        wr_dat_en  = (cur_st[RD_PIN] == ST_I);
        wr_dat     = pin_data;
      end else if (pin_state < cur_st[RD_PIN]) begin
        pout_valid    = 1'b1;
        pout_resp     = 1'b1;
        pout_addr     = pin_addr;
        pout_state    = pin_state;
        pout_has_data = (cur_st[RD_PIN] == ST_M);
        pout_data     = pout_has_data ? cur_dat[RD_PIN] : '0;
        if (pout_ready) begin
          pin_ready = 1'b1;
          wr_en     = 1'b1;
          wr_st_en  = 1'b1;
          wr_st     = msi_t'(pin_state);
        end
      end else begin
        // already at or below the asked state: consume silently
        pin_ready = 1'b1;
      end
    end else if (vd_valid) begin
      wr_idx = vd_addr;
      if (cur_pend[RD_VD].v) begin
        vd_ready = 1'b0;
      end else if (vd_state < cur_st[RD_VD]) begin
        pout_valid    = 1'b1;
        pout_resp     = 1'b1;
        pout_addr     = vd_addr;
        pout_state    = vd_state;
        pout_has_data = (cur_st[RD_VD] == ST_M);
        pout_data     = pout_has_data ? cur_dat[RD_VD] : '0;
        if (pout_ready) begin
          vd_ready = 1'b1;
          wr_en    = 1'b1;
          wr_st_en = 1'b1;
          wr_st    = msi_t'(vd_state);
        end
      end else begin
        vd_ready = 1'b1;
      end
    end else if (preq_valid) begin
      wr_idx = preq_addr;
      if (prq_hit) begin
        presp_valid = 1'b1;
        presp_store = preq_store;
        presp_data  = preq_store ? '0 : cur_dat[RD_PRQ];
        if (presp_ready) begin
          preq_ready = 1'b1;
          wr_en      = preq_store;
          wr_dat_en  = preq_store;
          wr_dat     = preq_data;
        end
      end else if (!cur_pend[RD_PRQ].v) begin
        pout_valid = 1'b1;
        pout_resp  = 1'b0;
        pout_addr  = preq_addr;
        pout_state = prq_want;
        if (pout_ready) begin
          wr_en      = 1'b1;
          wr_pend_en = 1'b1;
          wr_pend    = '{v: 1'b1, st: prq_want};
        end
      end
    end
  end
endmodule

// File: rtl/msi_l1_ctrl.sv
module msi_l1_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preq_valid,
  output logic              preq_ready,
  input  logic              preq_store,
  input  logic [ADDR_W-1:0] preq_addr,
  input  logic [DATA_W-1:0] preq_data,
  output logic              presp_valid,
  input  logic              presp_ready,
  output logic              presp_store,
  output logic [DATA_W-1:0] presp_data,
  output logic              pout_valid,
  input  logic              pout_ready,
  output logic              pout_resp,
  output logic [ADDR_W-1:0] pout_addr,
  output logic [1:0]        pout_state,
  output logic              pout_has_data,
  output logic [DATA_W-1:0] pout_data,
  input  logic              pin_valid,
  output logic              pin_ready,
  input  logic              pin_resp,
  input  logic [ADDR_W-1:0] pin_addr,
  input  logic [1:0]        pin_state,
  input  logic [DATA_W-1:0] pin_data,
  input  logic              vd_valid,
  output logic              vd_ready,
  input  logic [ADDR_W-1:0] vd_addr,
  input  logic [1:0]        vd_state
);
  localparam int LINES = 1 << ADDR_W;

  logic [NUM_RD-1:0][ADDR_W-1:0] rd_idx;
  msi_t  [NUM_RD-1:0]            cur_st;
  pend_t [NUM_RD-1:0]            cur_pend;
  logic  [NUM_RD-1:0][DATA_W-1:0] cur_dat;
  msi_t  [LINES-1:0]             line_st;
  logic  [LINES-1:0]             line_pv;

  logic              wr_en, wr_st_en, wr_pend_en, wr_dat_en;
  logic [ADDR_W-1:0] wr_idx;
  msi_t              wr_st;
  pend_t             wr_pend;
  logic [DATA_W-1:0] wr_dat;

  always_comb begin
    rd_idx         = '0;
    rd_idx[RD_PIN] = pin_addr;
    rd_idx[RD_VD]  = vd_addr;
    rd_idx[RD_PRQ] = preq_addr;
  end

  msi_line_store #(
    .LINES(LINES), .AW(ADDR_W), .DATA_W(DATA_W), .NRD(NUM_RD)
  ) u_lines (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_st_en(wr_st_en), .wr_st(wr_st),
    .wr_pend_en(wr_pend_en), .wr_pend(wr_pend),
    .wr_dat_en(wr_dat_en), .wr_dat(wr_dat),
    .rd_idx(rd_idx), .rd_st(cur_st), .rd_pend(cur_pend), .rd_dat(cur_dat),
    .all_st(line_st), .all_pv(line_pv)
  );

  msi_rule_engine #(.AW(ADDR_W), .DATA_W(DATA_W)) u_rules (
    .preq_valid(preq_valid), .preq_ready(preq_ready), .preq_store(preq_store),
    .preq_addr(preq_addr), .preq_data(preq_data),
    .presp_valid(presp_valid), .presp_ready(presp_ready),
    .presp_store(presp_store), .presp_data(presp_data),
    .pout_valid(pout_valid), .pout_ready(pout_ready), .pout_resp(pout_resp),
    .pout_addr(pout_addr), .pout_state(pout_state),
    .pout_has_data(pout_has_data), .pout_data(pout_data),
    .pin_valid(pin_valid), .pin_ready(pin_ready), .pin_resp(pin_resp),
    .pin_addr(pin_addr), .pin_state(pin_state), .pin_data(pin_data),
    .vd_valid(vd_valid), .vd_ready(vd_ready), .vd_addr(vd_addr), .vd_state(vd_state),
    .cur_st(cur_st), .cur_pend(cur_pend), .cur_dat(cur_dat),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_st_en(wr_st_en), .wr_st(wr_st),
    .wr_pend_en(wr_pend_en), .wr_pend(wr_pend),
    .wr_dat_en(wr_dat_en), .wr_dat(wr_dat)
  );
endmodule

// File: rtl/msi_l1_chk.sv
module msi_l1_chk #(
  parameter int ADDR_W = 3,
  parameter int LINES  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   pout_valid,
  input logic                   pout_ready,
  input logic                   pout_resp,
  input logic [ADDR_W-1:0]      pout_addr,
  input logic [1:0]             pout_state,
  input logic                   pout_has_data,
  input logic                   pin_valid,
  input logic                   pin_ready,
  input logic                   pin_resp,
  input logic [ADDR_W-1:0]      pin_addr,
  input logic [1:0]             pin_state,
  input logic                   presp_valid,
  input logic                   presp_store,
  input logic [ADDR_W-1:0]      preq_addr,
  input logic [LINES-1:0][1:0]  line_st,
  input logic [LINES-1:0]       line_pv
);
  p_one_outstanding_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pout_valid && !pout_resp) |-> !line_pv[pout_addr]);

  p_req_marks_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pout_valid && pout_ready && !pout_resp) |=> line_pv[$past(pout_addr)]);

  p_dn_below_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pout_valid && pout_resp) |-> (pout_state < line_st[pout_addr]));

  p_dn_data_from_m_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pout_valid && pout_resp) |-> (pout_has_data == (line_st[pout_addr] == 2'd2)));

  p_store_hit_in_m_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (presp_valid && presp_store) |-> (line_st[preq_addr] == 2'd2));

  p_load_hit_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    presp_valid |-> (line_st[preq_addr] != 2'd0));

  p_upgrade_install_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_valid && pin_ready && pin_resp) |=>
      (!line_pv[$past(pin_addr)] && line_st[$past(pin_addr)] == $past(pin_state)));

  p_drop_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_valid && !pin_resp && pin_state >= line_st[pin_addr]) |-> (!pout_valid && pin_ready));
endmodule

bind msi_l1_ctrl msi_l1_chk #(.ADDR_W(ADDR_W), .LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .pout_valid(pout_valid), .pout_ready(pout_ready), .pout_resp(pout_resp),
  .pout_addr(pout_addr), .pout_state(pout_state), .pout_has_data(pout_has_data),
  .pin_valid(pin_valid), .pin_ready(pin_ready), .pin_resp(pin_resp),
  .pin_addr(pin_addr), .pin_state(pin_state),
  .presp_valid(presp_valid), .presp_store(presp_store), .preq_addr(preq_addr),
  .line_st(line_st), .line_pv(line_pv)
);

// File: tb/tb_msi_l1_ctrl.sv
module tb_msi_l1_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic preq_valid, preq_store, presp_ready, pout_ready;
  logic [AW-1:0] preq_addr, pin_addr, vd_addr;
  logic [DW-1:0] preq_data, pin_data;
  logic pin_valid, pin_resp, vd_valid;
  logic [1:0] pin_state, vd_state;
  logic preq_ready, presp_valid, presp_store, pout_valid, pout_resp, pout_has_data;
  logic pin_ready, vd_ready;
  logic [DW-1:0] presp_data, pout_data;
  logic [AW-1:0] pout_addr;
  logic [1:0] pout_state;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_l1_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .preq_valid(preq_valid), .preq_ready(preq_ready), .preq_store(preq_store),
    .preq_addr(preq_addr), .preq_data(preq_data),
    .presp_valid(presp_valid), .presp_ready(presp_ready),
    .presp_store(presp_store), .presp_data(presp_data),
    .pout_valid(pout_valid), .pout_ready(pout_ready), .pout_resp(pout_resp),
    .pout_addr(pout_addr), .pout_state(pout_state),
    .pout_has_data(pout_has_data), .pout_data(pout_data),
    .pin_valid(pin_valid), .pin_ready(pin_ready), .pin_resp(pin_resp),
    .pin_addr(pin_addr), .pin_state(pin_state), .pin_data(pin_data),
    .vd_valid(vd_valid), .vd_ready(vd_ready), .vd_addr(vd_addr), .vd_state(vd_state)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic idle_all();
    preq_valid = 0; preq_store = 0; preq_addr = '0; preq_data = '0;
    pin_valid = 0; pin_resp = 0; pin_addr = '0; pin_state = 0; pin_data = '0;
    vd_valid = 0; vd_addr = '0; vd_state = 0;
    presp_ready = 1; pout_ready = 1;
  endtask

  task automatic proc(input logic st, input logic [AW-1:0] a, input logic [DW-1:0] d);
    preq_valid = 1; preq_store = st; preq_addr = a; preq_data = d;
  endtask

  task automatic par(input logic rsp, input logic [AW-1:0] a, input logic [1:0] s,
                     input logic [DW-1:0] d);
    pin_valid = 1; pin_resp = rsp; pin_addr = a; pin_state = s; pin_data = d;
  endtask

  // bring a line from I to the requested state through a full miss
  task automatic fill(input logic [AW-1:0] a, input logic [1:0] s, input logic [DW-1:0] d);
    proc(s == 2'd2, a, d);
    settle();
    tick();
    preq_valid = 0;
    par(1, a, s, d);
    tick();
    pin_valid = 0;
  endtask

  task automatic t_reset();
    settle();
    chk("R1 pout_valid idle", pout_valid, 0);
    chk("R1 presp_valid idle", presp_valid, 0);
    chk("R1 pin_ready idle", pin_ready, 0);
    proc(0, 0, 0);
    settle();
    chk("R1 line0 starts in I (load misses)", {pout_valid, pout_resp, pout_state}, {1'b1, 1'b0, 2'd1});
    preq_valid = 0;
    settle();
  endtask

  task automatic t_load_miss();
    proc(0, 1, 0);
    settle();
    chk("R4 load miss sends request", {pout_valid, pout_resp, pout_state, 1'b0, pout_addr}, {1'b1, 1'b0, 2'd1, 1'b0, 3'd1});
    chk("R4 load miss not dequeued", preq_ready, 0);
    tick();
    chk("R5 no second request while pending", pout_valid, 0);
    chk("R5 still blocked", preq_ready, 0);
    tick();
    par(1, 1, 2'd1, 16'hAAAA);
    settle();
    chk("R10 parent response wins over processor", {pin_ready, presp_valid}, 2'b10);
    tick();
    pin_valid = 0;
    settle();
    chk("R6 retry hits after install", {presp_valid, preq_ready}, 2'b11);
    chk("R6 data installed from I", presp_data, 16'hAAAA);
    chk("R2 load hit store flag 0", presp_store, 0);
    tick();
    preq_valid = 0;
  endtask

  task automatic t_upgrade_keeps_data();
    proc(1, 1, 16'h1234);
    settle();
    chk("R3 store to S is a miss", presp_valid, 0);
    chk("R4 store miss asks for M", {pout_valid, pout_resp, pout_state}, {1'b1, 1'b0, 2'd2});
    tick();
    preq_valid = 0;
    par(1, 1, 2'd2, 16'h5555);
    tick();
    pin_valid = 0;
    proc(0, 1, 0);
    settle();
    chk("R6 S->M upgrade keeps old data", presp_data, 16'hAAAA);
    tick();
    proc(1, 1, 16'h1234);
    settle();
    chk("R3 store hits in M", {presp_valid, presp_store, preq_ready}, 3'b111);
    tick();
    proc(0, 1, 0);
    settle();
    chk("R3 store data written", presp_data, 16'h1234);
    tick();
    preq_valid = 0;
  endtask

  task automatic t_downgrades();
    pout_ready = 0;
    par(0, 1, 2'd1, 0);
    settle();
    chk("R12 downgrade stalls on full queue", pin_ready, 0);
    tick();
    pout_ready = 1;
    settle();
    chk("R12 line unchanged after stall (still M, data)", {pout_valid, pout_has_data, pout_data}, {1'b1, 1'b1, 16'h1234});
    chk("R7 M->S response fields", {pout_resp, pout_state, pout_addr}, {1'b1, 2'd1, 3'd1});
    chk("R7 accepted", pin_ready, 1);
    tick();
    par(0, 1, 2'd1, 0);
    proc(0, 1, 0);
    settle();
    chk("R8 redundant downgrade silent", {pin_ready, pout_valid}, 2'b10);
    chk("R10 processor held behind parent message", presp_valid, 0);
    tick();
    pin_valid = 0;
    settle();
    chk("R8 line still readable in S", {presp_valid, presp_data}, {1'b1, 16'h1234});
    presp_ready = 0;
    settle();
    chk("R11 hit held while response queue full", preq_ready, 0);
    tick();
    presp_ready = 1;
    settle();
    chk("R11 hit completes afterwards", {preq_ready, presp_data}, {1'b1, 16'h1234});
    tick();
    preq_valid = 0;
    par(0, 1, 2'd0, 0);
    settle();
    chk("R7 S->I response carries no data", {pout_valid, pout_resp, pout_state, pout_has_data}, {1'b1, 1'b1, 2'd0, 1'b0});
    tick();
    pin_valid = 0;
    proc(0, 1, 0);
    settle();
    chk("R7 line now in I (load misses)", {pout_valid, pout_resp}, 2'b10);
    preq_valid = 0;
    settle();
  endtask

  task automatic t_voluntary();
    fill(2, 2'd2, 16'h0F0F);
    proc(1, 2, 16'hBEEF);
    settle();
    tick();
    preq_valid = 0;
    vd_valid = 1; vd_addr = 2; vd_state = 2'd0;
    proc(0, 3, 0);
    settle();
    chk("R9 voluntary M->I sends data", {pout_valid, pout_resp, pout_state, pout_has_data, pout_data},
        {1'b1, 1'b1, 2'd0, 1'b1, 16'hBEEF});
    chk("R10 voluntary wins over processor", {vd_ready, pout_addr}, {1'b1, 3'd2});
    tick();
    vd_valid = 0;
    preq_valid = 0;
    fill(4, 2'd1, 16'h4444);
    proc(1, 4, 16'h9999);
    settle();
    tick();
    preq_valid = 0;
    vd_valid = 1; vd_addr = 4; vd_state = 2'd0;
    settle();
    chk("R9 voluntary held while pending", {vd_ready, pout_valid}, 2'b00);
    tick();
    vd_valid = 0;
    par(1, 4, 2'd2, 0);
    tick();
    pin_valid = 0;
    vd_valid = 1; vd_addr = 4; vd_state = 2'd2;
    settle();
    chk("R9 voluntary to same state consumed silently", {vd_ready, pout_valid}, 2'b10);
    tick();
    vd_valid = 0;
    proc(0, 4, 0);
    settle();
    chk("R9 line kept M and old data", {presp_valid, presp_data}, {1'b1, 16'h4444});
    tick();
    preq_valid = 0;
  endtask

  initial begin
    idle_all();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    par(1, 0, 2'd1, 16'h1111);
    tick();
    pin_valid = 0;
    t_load_miss();
    t_upgrade_keeps_data();
    t_downgrades();
    par(1, 1, 2'd1, 16'h7777);
    tick();
    pin_valid = 0;
    t_voluntary();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule